// File: doc/BRIEF.md
# Panel Display Timing Generator

This block produces the line and frame timing for a parallel RGB panel. It runs from a fast display clock. A fractional divider turns that clock into a one-cycle pixel strobe. Each strobe moves a horizontal phase machine forward by one pixel. When a line ends, the horizontal machine steps a vertical phase machine that has the same shape. Both machines go through five phases in a fixed order: a one-pixel reference slot, sync, back porch, active and front porch.

Four 32-bit words set the timing: sync width, back porch, front porch and active size. Each word carries a horizontal count and a vertical count. The reference-to-sync slot is fixed at one pixel and is taken out of the panel's front porch. The programmed front porch is therefore one less than the front porch the panel needs. The divider value `D` has seven integer bits and one half-step bit, and gives one pixel every `(D+2)/2` display clocks. Software obtains it as round(2·f_disp/f_pix) − 2.

The block takes a copy of the configuration words and the divider value while it is disabled. While it runs, it takes a new copy only at the end of a frame, so a mid-frame write never tears a frame. The outputs are hsync, vsync, data enable, the active pixel column and row, the pixel strobe and a frame-start pulse.

Top module: `disp_timing_gen`

States. Horizontal and vertical machines: PH_REF → PH_SYNC → PH_BACK → PH_ACTIVE → PH_FRONT → PH_REF. A machine moves on to the next phase on a step that lands on the last count of the current phase. Divider half-step machine: HALF_SHORT ⇄ HALF_LONG, toggling on every pixel strobe.

## Requirements
- R1: In every timing word, bits 15:0 hold the horizontal count and bits 31:16 the vertical count. The words are sync width, back porch, front porch and active size. The active word holds width in the low half and height in the high half.
- R2: A line lasts 1 + S + B + A + F pixels (sync S, back porch B, active A, programmed front porch F, horizontal halves). It is laid out in this order: one reference pixel at position 0, then S sync pixels, B back-porch pixels, A active pixels and F front-porch pixels.
- R3: The vertical machine steps once per completed line and has the same five-phase layout in lines, using the vertical halves. vsync is active for every pixel of the vertical sync lines.
- R4: de is high only when both machines are in the active phase. During de, px_x and px_y give the column and row, counted from 0. Outside de, both read 0.
- R5: With divider value D, the gap from enable (or from the previous strobe) to the next strobe is ⌊D/2⌋+1 clocks for the 1st, 3rd, 5th… strobe and ⌊D/2⌋+1+(D mod 2) clocks for the 2nd, 4th…. Every two pixels therefore take exactly D+2 clocks.
- R6: pix_en is a single-clock pulse when D ≥ 2. hsync, vsync, de, px_x and px_y change only on the clock edge where pix_en is high.
- R7: frame_start is high for exactly the clock on which pix_en is high while the first active pixel of the first active line (column 0, row 0) is shown.
- R8: While en is high, changes to the timing words and the divider take effect only from the first pixel of the next frame. While en is low, they are copied every clock.
- R9: While en is low, de, pix_en and frame_start are 0 and the syncs are inactive. Raising en starts a frame at the reference pixel of the reference line.
- R10: With the default polarity parameter, hsync and vsync are active high.
- R11: After reset, every output is at its idle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds the timing at rest |
| div_in | input | 8 | Pixel divider, 7.1 fixed point |
| tm_sync | input | 32 | Sync widths {vertical, horizontal} |
| tm_back | input | 32 | Back porches {vertical, horizontal} |
| tm_front | input | 32 | Programmed front porches {vertical, horizontal} |
| tm_active | input | 32 | Active size {height, width} |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_en | output | 1 | Pixel strobe, one display clock wide |
| px_x | output | 16 | Active column |
| px_y | output | 16 | Active row |
| frame_start | output | 1 | First active pixel of a frame |

## Verification
The assertions assume that every phase count is at least 1. A zero count would make a phase last a full counter wrap instead of being skipped. They also assume that the configuration is steady for at least one clock before en rises. The single-clock strobe check holds only for divider values of 2 or more, because values 0 and 1 legally give back-to-back strobes. The stimulus applies configurations with all counts from 1 to 4, holds them for several clocks with en low before enabling, sweeps the divider over its low values including both parities, and changes the words mid-frame only while running. It then predicts each pixel's phase from its index within the frame.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    typedef enum logic [2:0] {
        PH_REF,
        PH_SYNC,
        PH_BACK,
        PH_ACTIVE,
        PH_FRONT
    } phase_e;

    typedef enum logic {
        HALF_SHORT,
        HALF_LONG
    } half_e;

endpackage

// File: rtl/dtg_pixdiv.sv
module dtg_pixdiv
    import dtg_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             pix_en
);

    half_e            half_q, half_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;
    logic             extra;

    // Each pixel lasts floor(div/2)+1 clocks; odd values add one clock on alternate pixels.
    always_comb begin
        extra  = div[0] && (half_q == HALF_LONG);
        limit  = (div >> 1) + {{(DIV_W-1){1'b0}}, extra};
        pix_en = run && (cnt_q == limit);
        half_d = half_q;
        unique case (half_q)
            HALF_SHORT: if (pix_en) half_d = HALF_LONG;
            HALF_LONG:  if (pix_en) half_d = HALF_SHORT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= HALF_SHORT;
            cnt_q  <= '0;
        end else if (!run) begin
            half_q <= HALF_SHORT;
            cnt_q  <= '0;
        end else begin
            half_q <= half_d;
            cnt_q  <= pix_en ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dtg_axis.sv
module dtg_axis
    import dtg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] len_sync,
    input  logic [CNT_W-1:0] len_back,
    input  logic [CNT_W-1:0] len_act,
    input  logic [CNT_W-1:0] len_front,
    output phase_e           phase,
    output logic [CNT_W-1:0] pos,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] REF_LEN = CNT_W'(1);

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] cur_len;
    logic             last;

    always_comb begin
        cur_len = REF_LEN;
        ph_d    = ph_q;
        unique case (ph_q)
            PH_REF:    begin cur_len = REF_LEN;   ph_d = PH_SYNC;   end
            PH_SYNC:   begin cur_len = len_sync;  ph_d = PH_BACK;   end
            PH_BACK:   begin cur_len = len_back;  ph_d = PH_ACTIVE; end
            PH_ACTIVE: begin cur_len = len_act;   ph_d = PH_FRONT;  end
            PH_FRONT:  begin cur_len = len_front; ph_d = PH_REF;    end
            default:   begin cur_len = REF_LEN;   ph_d = PH_REF;    end
        endcase
        last = (pos_q == cur_len - 1'b1);
        wrap = step && last && (ph_q == PH_FRONT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_REF;
            pos_q <= '0;
        end else if (!run) begin
            ph_q  <= PH_REF;
            pos_q <= '0;
        end else if (step) begin
            if (last) begin
                ph_q  <= ph_d;
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign phase = ph_q;
    assign pos   = pos_q;

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DIV_W     = 8,
    parameter bit SYNC_HIGH = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [DIV_W-1:0]   div_in,
    input  logic [2*CNT_W-1:0] tm_sync,
    input  logic [2*CNT_W-1:0] tm_back,
    input  logic [2*CNT_W-1:0] tm_front,
    input  logic [2*CNT_W-1:0] tm_active,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic               pix_en,
    output logic [CNT_W-1:0]   px_x,
    output logic [CNT_W-1:0]   px_y,
    output logic               frame_start
);

    localparam int WORD_W = 2 * CNT_W;

    logic [WORD_W-1:0] sync_q, back_q, front_q, act_q;
    logic [DIV_W-1:0]  div_q;
    logic              cfg_load;
    logic              h_wrap, v_wrap;
    phase_e            h_ph, v_ph;
    logic [CNT_W-1:0]  h_pos, v_pos;
    logic              hs_act, vs_act, de_int;

    // Shadow copy: tracks inputs while idle, refreshed only at the frame boundary while running.
    assign cfg_load = !en || v_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            back_q  <= '0;
            front_q <= '0;
            act_q   <= '0;
            div_q   <= '0;
        end else if (cfg_load) begin
            sync_q  <= tm_sync;
            back_q  <= tm_back;
            front_q <= tm_front;
            act_q   <= tm_active;
            div_q   <= div_in;
        end
    end

    dtg_pixdiv #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en),
        .div    (div_q),
        .pix_en (pix_en)
    );

    dtg_axis #(.CNT_W(CNT_W)) u_h (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (en),
        .step      (pix_en),
        .len_sync  (sync_q[CNT_W-1:0]),
        .len_back  (back_q[CNT_W-1:0]),
        .len_act   (act_q[CNT_W-1:0]),
        .len_front (front_q[CNT_W-1:0]),
        .phase     (h_ph),
        .pos       (h_pos),
        .wrap      (h_wrap)
    );

    dtg_axis #(.CNT_W(CNT_W)) u_v (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (en),
        .step      (h_wrap),
        .len_sync  (sync_q[WORD_W-1:CNT_W]),
        .len_back  (back_q[WORD_W-1:CNT_W]),
        .len_act   (act_q[WORD_W-1:CNT_W]),
        .len_front (front_q[WORD_W-1:CNT_W]),
        .phase     (v_ph),
        .pos       (v_pos),
        .wrap      (v_wrap)
    );

    always_comb begin
        hs_act      = en && (h_ph == PH_SYNC);
        vs_act      = en && (v_ph == PH_SYNC);
        de_int      = en && (h_ph == PH_ACTIVE) && (v_ph == PH_ACTIVE);
        de          = de_int;
        px_x        = de_int ? h_pos : '0;
        px_y        = de_int ? v_pos : '0;
        frame_start = pix_en && de_int && (h_pos == '0) && (v_pos == '0);
    end

    generate
        if (SYNC_HIGH) begin : g_pos_sync
            assign hsync = hs_act;
            assign vsync = vs_act;
        end else begin : g_neg_sync
            assign hsync = !hs_act;
            assign vsync = !vs_act;
        end
    endgenerate

endmodule

// File: rtl/dtg_chk.sv
module dtg_chk #(
    parameter int CNT_W     = 16,
    parameter int DIV_W     = 8,
    parameter bit SYNC_HIGH = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               hsync,
    input logic               vsync,
    input logic               de,
    input logic               pix_en,
    input logic [CNT_W-1:0]   px_x,
    input logic [CNT_W-1:0]   px_y,
    input logic               frame_start,
    input logic               cfg_load,
    input logic [DIV_W-1:0]   div_q,
    input logic [2*CNT_W-1:0] act_q,
    input logic [2*CNT_W-1:0] sync_q
);

    // R9
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!de && !pix_en && !frame_start));

    // R7
    frame_start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (de && pix_en && px_x == '0 && px_y == '0));

    // R6
    hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !pix_en) |=> (!en || ($stable(de) && $stable(px_x) && $stable(px_y) && $stable(hsync))));

    // R5
    single_clock_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !cfg_load && div_q > DIV_W'(1)) |=> !pix_en);

    // R8
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cfg_load) |=> ($stable(act_q) && $stable(sync_q) && $stable(div_q)));

    // R4
    de_sync_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> ((hsync != SYNC_HIGH) && (vsync != SYNC_HIGH)));

endmodule

bind disp_timing_gen dtg_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W), .SYNC_HIGH(SYNC_HIGH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .hsync       (hsync),
    .vsync       (vsync),
    .de          (de),
    .pix_en      (pix_en),
    .px_x        (px_x),
    .px_y        (px_y),
    .frame_start (frame_start),
    .cfg_load    (cfg_load),
    .div_q       (div_q),
    .act_q       (act_q),
    .sync_q      (sync_q)
);

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [7:0]  div_in = '0;
    logic [31:0] tm_sync = '0, tm_back = '0, tm_front = '0, tm_active = '0;
    logic        hsync, vsync, de, pix_en, frame_start;
    logic [15:0] px_x, px_y;

    int n_chk = 0;
    int n_bad = 0;
    int cfgA[8];
    int cfgB[8];
    bit e_hs, e_vs, e_de;
    int e_x, e_y;

    always #2.5 clk = ~clk;

    disp_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div_in(div_in),
        .tm_sync(tm_sync), .tm_back(tm_back), .tm_front(tm_front), .tm_active(tm_active),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_en(pix_en),
        .px_x(px_x), .px_y(px_y), .frame_start(frame_start)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Index order: 0..3 horizontal sync/back/active/front, 4..7 the vertical ones.
    task automatic drive_cfg(input int c[8]);
        tm_sync   = {16'(c[4]), 16'(c[0])};
        tm_back   = {16'(c[5]), 16'(c[1])};
        tm_active = {16'(c[6]), 16'(c[2])};
        tm_front  = {16'(c[7]), 16'(c[3])};
    endtask

    function automatic void axis_model(input int pos, input int s, input int b, input int a,
                                       output bit in_sync, output bit in_act, output int idx);
        in_sync = (pos >= 1) && (pos <= s);
        in_act  = (pos >= 1 + s + b) && (pos < 1 + s + b + a);
        idx     = pos - (1 + s + b);
    endfunction

    function automatic void model(input int p);
        int c[8];
        int q, ht, vt, ft;
        bit ha, va;
        int hx, vy;
        ht = 1 + cfgA[0] + cfgA[1] + cfgA[2] + cfgA[3];
        vt = 1 + cfgA[4] + cfgA[5] + cfgA[6] + cfgA[7];
        ft = ht * vt;
        if (p < ft) begin
            c = cfgA; q = p;
        end else begin
            c = cfgB;
            ht = 1 + c[0] + c[1] + c[2] + c[3];
            vt = 1 + c[4] + c[5] + c[6] + c[7];
            q = (p - ft) % (ht * vt);
        end
        axis_model(q % ht, c[0], c[1], c[2], e_hs, ha, hx);
        axis_model(q / ht, c[4], c[5], c[6], e_vs, va, vy);
        e_de = ha && va;
        e_x  = e_de ? hx : 0;
        e_y  = e_de ? vy : 0;
    endfunction

    // Runs npix pixels with divider d; at pixel sw (if >= 0) the inputs switch to cfgB.
    task automatic run_case(input int d, input int npix, input int sw);
        int cyc, n, p, per;
        bit exp_pe, exp_fs, switched;
        if (sw < 0) cfgB = cfgA;
        @(negedge clk);
        en = 1'b0;
        div_in = 8'(d);
        drive_cfg(cfgA);
        repeat (3) @(negedge clk);
        en = 1'b1;
        cyc = 0; n = 0; p = 0; switched = 0;
        while (p < npix) begin
            #1;
            cyc++;
            per = d / 2 + 1 + (((n % 2) == 1) ? (d % 2) : 0);
            exp_pe = (cyc == per);
            model(p);
            exp_fs = exp_pe && e_de && (e_x == 0) && (e_y == 0);
            check(pix_en == exp_pe, "R5 pix_en gap", int'(pix_en), int'(exp_pe));
            check(hsync == e_hs, "R2 R10 hsync", int'(hsync), int'(e_hs));
            check(vsync == e_vs, "R3 vsync", int'(vsync), int'(e_vs));
            check(de == e_de, "R4 de", int'(de), int'(e_de));
            check(int'(px_x) == e_x, "R4 px_x", int'(px_x), e_x);
            check(int'(px_y) == e_y, "R4 px_y", int'(px_y), e_y);
            check(frame_start == exp_fs, "R7 frame_start", int'(frame_start), int'(exp_fs));
            if (exp_pe) begin
                p++; n++; cyc = 0;
            end
            if (!switched && sw >= 0 && p == sw) begin
                drive_cfg(cfgB);      // R8 mid-frame write
                switched = 1;
            end
            @(negedge clk);
        end
        en = 1'b0;
        #1;
        // R9 idle while disabled
        check(!de && !pix_en && !hsync && !vsync && !frame_start, "R9 idle after disable",
              int'({de, pix_en, hsync, vsync, frame_start}), 0);
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R11 reset state
        check(!hsync && !vsync && !de && !pix_en && !frame_start && px_x == 0 && px_y == 0,
              "R11 reset outputs", int'({hsync, vsync, de, pix_en, frame_start}), 0);
        rst_n = 1'b1;

        // R1 R2 R3: small frame, divider swept through both parities
        cfgA = '{2, 3, 4, 2, 1, 2, 3, 1};
        for (int d = 0; d < 6; d++) run_case(d, 110, -1);
        run_case(9, 60, -1);

        // R2 R3: every phase one long, frame of 25 pixels
        cfgA = '{1, 1, 1, 1, 1, 1, 1, 1};
        run_case(0, 60, -1);
        run_case(3, 60, -1);

        // R8: mid-frame rewrite appears only from the next frame
        cfgA = '{2, 1, 3, 2, 1, 1, 2, 1};
        cfgB = '{1, 2, 4, 1, 2, 1, 3, 2};
        run_case(2, 130, 10);
        cfgA = '{3, 2, 2, 4, 2, 3, 4, 1};
        cfgB = '{1, 1, 1, 1, 1, 1, 1, 1};
        run_case(1, 260, 40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule